// File: doc/BRIEF.md
# Port Pattern-Match Interrupt Unit

This unit watches an input port of `W` bits (8 by default) and raises an interrupt when the port matches a programmed pattern. Software sets the pattern through a synchronous write-only register interface. For each bit it chooses three things: whether the bit takes part, whether the bit reacts to an edge or to a level, and which polarity the bit needs. A separate inversion mask flips chosen input lines before matching, so an active-low line can be tested like any other. The mode register combines the selected bits. In OR mode any matching bit is enough. In AND mode every selected bit must match in the same cycle.

A match sets the pending flag. Software can set the under-service flag to acknowledge it. One command clears both flags together, and two other commands set and clear the port interrupt enable. The interrupt request goes out only when a match is pending and not under service, the port enable is set and the global enable is set.

The input bus is sampled on every clock with no handshake. The port carries level signals, not a stream, so it has no valid/ready pair and it never applies back-pressure. The write interface is also a plain strobe with no back-pressure. Every write is taken in the cycle `wr_en` is high.

Top module: `port_match_irq`

## Requirements
- R1: Only bits whose mask bit is 1 take part in matching. With an all-zero mask the unit never raises the pending flag.
- R2: A transition bit of 1 makes that bit edge-sensitive, and 0 makes it level-sensitive. An edge means the registered sample differs from the sample taken one clock earlier.
- R3: A polarity bit of 1 asks for a rising edge or a high level. A polarity bit of 0 asks for a falling edge or a low level.
- R4: The mode register (offset 1, bits [1:0]) selects the matching: 00 is disabled, 01 is OR (any selected bit), 10 is AND (all selected bits, and at least one must be selected). The code 11 behaves as disabled.
- R5: In AND mode only the lowest-numbered bit that is both selected and edge-sensitive is treated as an edge. Any other selected bits marked edge-sensitive are checked as levels with their polarity.
- R6: The inversion register (offset 5) flips every input bit whose inversion bit is 1 before edge and level detection.
- R7: Writing the command register (offset 6) with bit 0 set clears the pending and under-service flags together. A clear takes priority over a match in the same cycle. A level match that still holds sets pending again on the next clock.
- R8: In the command register, bit 1 sets the port interrupt enable, bit 2 clears it (and wins if both are set), and bit 3 sets the under-service flag.
- R9: `irq` is high exactly when pending is set, under-service is clear, the port interrupt enable is set and the global enable (control offset 0, bit 1) is set.
- R10: Writes to the mode, mask (offset 2), transition (offset 3), polarity (offset 4) and inversion registers are ignored while the port enable (control offset 0, bit 0) is 1. Matching only happens while the port enable is 1.
- R11: After reset every register and flag is 0. An input change made before one clock edge sets the pending flag at the next edge after that one, so it shows two edges after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register offset |
| wr_data | input | W | Write data |
| din | input | W | Monitored input port |
| irq | output | 1 | Interrupt request |
| int_pending | output | 1 | Pattern match pending flag |
| int_in_service | output | 1 | Interrupt under-service flag |

## Verification
The assertions check on every cycle the parts of the behaviour that hold in any state:
- `irq` is never high without pending, both enables and no service in progress.
- A clear or enable-clear command always takes effect on the next clock.
- The mask register keeps its value when it is written while the port is enabled.
- No match is produced when the mask is all zero or the mode is disabled or reserved.

Only the bench scenarios show the pattern results themselves: which edge and level combinations match under OR and AND, the lowest-edge rule in AND mode, inversion, the re-raising of a persisting level match after a clear, and the exact two-edge latency.

// File: rtl/pmi_pkg.sv
package pmi_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_OR   = 2'b01,
    MODE_AND  = 2'b10,
    MODE_RSVD = 2'b11
  } match_mode_e;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_MODE = 3'd1;
  localparam logic [ADDR_W-1:0] A_MASK = 3'd2;
  localparam logic [ADDR_W-1:0] A_EDGE = 3'd3;
  localparam logic [ADDR_W-1:0] A_POL  = 3'd4;
  localparam logic [ADDR_W-1:0] A_INV  = 3'd5;
  localparam logic [ADDR_W-1:0] A_CMD  = 3'd6;

  localparam int CTRL_PORT_EN = 0;
  localparam int CTRL_MIE     = 1;
  localparam int CMD_CLR      = 0;
  localparam int CMD_IE_SET   = 1;
  localparam int CMD_IE_CLR   = 2;
  localparam int CMD_IUS_SET  = 3;
endpackage

// File: rtl/pmi_regs.sv
module pmi_regs
  import pmi_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  output logic              port_en,
  output logic              mie,
  output match_mode_e       mode,
  output logic [W-1:0]      mask,
  output logic [W-1:0]      edge_sel,
  output logic [W-1:0]      pol,
  output logic [W-1:0]      inv,
  output logic              cmd_clr,
  output logic              cmd_ie_set,
  output logic              cmd_ie_clr,
  output logic              cmd_ius_set
);
  logic cmd_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_en  <= 1'b0;
      mie      <= 1'b0;
      mode     <= MODE_OFF;
      mask     <= '0;
      edge_sel <= '0;
      pol      <= '0;
      inv      <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_CTRL) begin
        port_en <= wr_data[CTRL_PORT_EN];
        mie     <= wr_data[CTRL_MIE];
      end
      // R10: pattern set is frozen while the port is enabled
      if (!port_en) begin
        case (wr_addr)
          A_MODE:  mode     <= match_mode_e'(wr_data[1:0]);
          A_MASK:  mask     <= wr_data;
          A_EDGE:  edge_sel <= wr_data;
          A_POL:   pol      <= wr_data;
          A_INV:   inv      <= wr_data;
          default: ;
        endcase
      end
    end
  end

  assign cmd_hit     = wr_en && (wr_addr == A_CMD);
  assign cmd_clr     = cmd_hit && wr_data[CMD_CLR];
  assign cmd_ie_set  = cmd_hit && wr_data[CMD_IE_SET];
  assign cmd_ie_clr  = cmd_hit && wr_data[CMD_IE_CLR];
  assign cmd_ius_set = cmd_hit && wr_data[CMD_IUS_SET];

  a_r10_mask_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && wr_en && wr_addr == A_MASK) |=> $stable(mask));
  a_r10_pol_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && wr_en && wr_addr == A_POL) |=> $stable(pol));
endmodule

// File: rtl/pmi_match.sv
module pmi_match
  import pmi_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  input  logic [W-1:0] inv,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] edge_sel,
  input  logic [W-1:0] pol,
  input  match_mode_e  mode,
  input  logic         port_en,
  output logic         match
);
  logic [W-1:0] cur, prev;
  logic [W-1:0] em, seen, pick, eff_edge, hit;
  logic         any_hit, all_hit;

  // R2/R6: register the inverted sample and keep one older copy
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur  <= '0;
      prev <= '0;
    end else begin
      cur  <= din ^ inv;
      prev <= cur;
    end
  end

  for (genvar gi = 0; gi < W; gi++) begin : g_bit
    assign em[gi] = edge_sel[gi] & mask[gi];
    if (gi == 0) begin : g_first
      assign seen[gi] = 1'b0;
    end else begin : g_rest
      assign seen[gi] = seen[gi-1] | em[gi-1];
    end
    // R5: in AND mode only the lowest selected edge bit is an edge
    assign pick[gi]     = em[gi] & ~seen[gi];
    assign eff_edge[gi] = (mode == MODE_AND) ? pick[gi] : em[gi];
    // R2/R3
    assign hit[gi] = eff_edge[gi]
                   ? (pol[gi] ? (cur[gi] & ~prev[gi]) : (~cur[gi] & prev[gi]))
                   : (cur[gi] == pol[gi]);
  end

  assign any_hit = |(hit & mask);
  assign all_hit = (&(hit | ~mask)) && (|mask);

  always_comb begin
    match = 1'b0;
    if (port_en) begin
      case (mode)
        MODE_OR:  match = any_hit;
        MODE_AND: match = all_hit;
        default:  match = 1'b0;
      endcase
    end
  end

  a_r1_empty_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !match);
  a_r4_off_modes: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_OFF || mode == MODE_RSVD) |-> !match);
endmodule

// File: rtl/pmi_irq.sv
module pmi_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic match,
  input  logic mie,
  input  logic cmd_clr,
  input  logic cmd_ie_set,
  input  logic cmd_ie_clr,
  input  logic cmd_ius_set,
  output logic ip,
  output logic ius,
  output logic ie,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ip  <= 1'b0;
      ius <= 1'b0;
      ie  <= 1'b0;
    end else begin
      // R7: clear beats a same-cycle match
      if (cmd_clr)    ip <= 1'b0;
      else if (match) ip <= 1'b1;

      if (cmd_clr)          ius <= 1'b0;
      else if (cmd_ius_set) ius <= 1'b1;

      // R8: clear wins over set
      if (cmd_ie_clr)      ie <= 1'b0;
      else if (cmd_ie_set) ie <= 1'b1;
    end
  end

  assign irq = ie & mie & ip & ~ius;

  a_r7_clear_flags: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_clr |=> (!ip && !ius));
  a_r8_ie_off: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ie_clr |=> !ie);
  a_r7_hold_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (ip && !cmd_clr) |=> ip);
endmodule

// File: rtl/port_match_irq.sv
module port_match_irq
  import pmi_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  input  logic [W-1:0]      din,
  output logic              irq,
  output logic              int_pending,
  output logic              int_in_service
);
  logic        port_en, mie, ie, match;
  match_mode_e mode;
  logic [W-1:0] mask, edge_sel, pol, inv;
  logic cmd_clr, cmd_ie_set, cmd_ie_clr, cmd_ius_set;

  pmi_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .port_en(port_en), .mie(mie), .mode(mode),
    .mask(mask), .edge_sel(edge_sel), .pol(pol), .inv(inv),
    .cmd_clr(cmd_clr), .cmd_ie_set(cmd_ie_set), .cmd_ie_clr(cmd_ie_clr),
    .cmd_ius_set(cmd_ius_set)
  );

  pmi_match #(.W(W)) u_match (
    .clk(clk), .rst_n(rst_n), .din(din), .inv(inv), .mask(mask),
    .edge_sel(edge_sel), .pol(pol), .mode(mode), .port_en(port_en),
    .match(match)
  );

  pmi_irq u_irq (
    .clk(clk), .rst_n(rst_n), .match(match), .mie(mie),
    .cmd_clr(cmd_clr), .cmd_ie_set(cmd_ie_set), .cmd_ie_clr(cmd_ie_clr),
    .cmd_ius_set(cmd_ius_set), .ip(int_pending), .ius(int_in_service),
    .ie(ie), .irq(irq)
  );

  a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ie && mie && int_pending && !int_in_service));
  a_r10_no_match_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |-> !match);
endmodule

// File: tb/port_match_irq_test.sv
`timescale 1ns/1ps
module port_match_irq_test;
  localparam int W = 8;
  localparam int NV = 15;
  // {mode, mask, edge, pol, inv, din_before, din_after, expected}
  localparam logic [50:0] VEC [NV] = '{
    {2'b01, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h01, 1'b1}, // R2 R3 rising
    {2'b01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 8'h01, 1'b0}, // R3 wrong edge
    {2'b01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h01, 8'h00, 1'b1}, // R3 falling
    {2'b01, 8'h0F, 8'h00, 8'h0F, 8'h00, 8'h00, 8'h04, 1'b1}, // R4 OR level
    {2'b01, 8'hF0, 8'h00, 8'hF0, 8'h00, 8'h00, 8'h0F, 1'b0}, // R1 unmasked bits
    {2'b10, 8'h03, 8'h00, 8'h03, 8'h00, 8'h00, 8'h01, 1'b0}, // R4 AND partial
    {2'b10, 8'h03, 8'h00, 8'h03, 8'h00, 8'h00, 8'h03, 1'b1}, // R4 AND full
    {2'b10, 8'h03, 8'h00, 8'h01, 8'h00, 8'h00, 8'h01, 1'b1}, // R3 mixed levels
    {2'b00, 8'hFF, 8'h00, 8'hFF, 8'h00, 8'h00, 8'hFF, 1'b0}, // R4 disabled
    {2'b11, 8'hFF, 8'h00, 8'hFF, 8'h00, 8'h00, 8'hFF, 1'b0}, // R4 reserved
    {2'b01, 8'h80, 8'h00, 8'h80, 8'h80, 8'h80, 8'h00, 1'b1}, // R6 inversion
    {2'b10, 8'h03, 8'h01, 8'h03, 8'h00, 8'h02, 8'h03, 1'b1}, // R5 edge+level
    {2'b10, 8'h03, 8'h03, 8'h03, 8'h00, 8'h02, 8'h03, 1'b1}, // R5 lowest edge
    {2'b10, 8'h03, 8'h03, 8'h03, 8'h00, 8'h01, 8'h03, 1'b0}, // R5 upper is level
    {2'b01, 8'h00, 8'h00, 8'hFF, 8'h00, 8'h00, 8'hFF, 1'b0}  // R1 empty mask
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] din = '0;
  logic irq, int_pending, int_in_service;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  port_match_irq #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .din(din), .irq(irq), .int_pending(int_pending),
    .int_in_service(int_in_service)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cfg(input logic [1:0] m, input logic [7:0] mk, input logic [7:0] ed,
                     input logic [7:0] pl, input logic [7:0] iv);
    wr(3'd0, 8'h00);
    wr(3'd1, {6'd0, m});
    wr(3'd2, mk);
    wr(3'd3, ed);
    wr(3'd4, pl);
    wr(3'd5, iv);
  endtask

  task automatic arm();
    wr(3'd0, 8'h03);
    wr(3'd6, 8'h02);
    wr(3'd6, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11 reset irq", {7'd0, irq}, 8'h0);
    check("R11 reset pending", {7'd0, int_pending}, 8'h0);
    check("R11 reset in-service", {7'd0, int_in_service}, 8'h0);

    for (int i = 0; i < NV; i++) begin
      cfg(VEC[i][50:49], VEC[i][48:41], VEC[i][40:33], VEC[i][32:25], VEC[i][24:17]);
      din = VEC[i][16:9];
      repeat (3) @(negedge clk);
      arm();
      din = VEC[i][8:1];
      repeat (3) @(negedge clk);
      check($sformatf("R1/R2/R3/R4/R5/R6 vector %0d pending", i), {7'd0, int_pending}, {7'd0, VEC[i][0]});
      check($sformatf("R9 vector %0d irq", i), {7'd0, irq}, {7'd0, VEC[i][0]});
    end

    // R9 / R8 gating
    cfg(2'b01, 8'h01, 8'h00, 8'h01, 8'h00);
    din = 8'h00;
    repeat (3) @(negedge clk);
    arm();
    din = 8'h01;
    repeat (3) @(negedge clk);
    check("R9 all enables", {7'd0, irq}, 8'h1);
    wr(3'd6, 8'h04);
    check("R8 ie cleared irq", {7'd0, irq}, 8'h0);
    check("R8 pending kept", {7'd0, int_pending}, 8'h1);
    wr(3'd6, 8'h06);
    check("R8 clear beats set", {7'd0, irq}, 8'h0);
    wr(3'd6, 8'h02);
    check("R8 ie set irq", {7'd0, irq}, 8'h1);
    wr(3'd0, 8'h01);
    check("R9 global off", {7'd0, irq}, 8'h0);
    wr(3'd0, 8'h03);
    check("R9 global on", {7'd0, irq}, 8'h1);
    wr(3'd6, 8'h08);
    check("R8 in-service set", {7'd0, int_in_service}, 8'h1);
    check("R9 in-service masks irq", {7'd0, irq}, 8'h0);
    wr(3'd6, 8'h01);
    check("R7 clear pending", {7'd0, int_pending}, 8'h0);
    check("R7 clear in-service", {7'd0, int_in_service}, 8'h0);
    @(negedge clk);
    check("R7 level re-raise", {7'd0, int_pending}, 8'h1);
    check("R7 irq back", {7'd0, irq}, 8'h1);

    // R10 writes ignored while enabled: try moving mask to bit1
    wr(3'd2, 8'h02);
    din = 8'h00;
    repeat (2) @(negedge clk);
    wr(3'd6, 8'h01);
    repeat (3) @(negedge clk);
    check("R10 mask write ignored", {7'd0, int_pending}, 8'h0);
    din = 8'h01;
    repeat (3) @(negedge clk);
    check("R10 old mask active", {7'd0, int_pending}, 8'h1);

    // R11 latency
    cfg(2'b01, 8'h01, 8'h01, 8'h01, 8'h00);
    din = 8'h00;
    repeat (3) @(negedge clk);
    arm();
    din = 8'h01;
    @(negedge clk);
    check("R11 one edge not yet", {7'd0, int_pending}, 8'h0);
    @(negedge clk);
    check("R11 second edge pending", {7'd0, int_pending}, 8'h1);

    // R10 disabled port never matches
    wr(3'd0, 8'h02);
    wr(3'd6, 8'h01);
    din = 8'h00;
    @(negedge clk);
    din = 8'h01;
    repeat (3) @(negedge clk);
    check("R10 disabled port", {7'd0, int_pending}, 8'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule